// File: doc/BRIEF.md
# Supply Startup Sequencer and Reset Shaper

This block is a small synchronous controller that runs from a slow internal master clock (about 10 kHz). When the power-on reset lets go, it waits a short settle time, switches on the supply reference, and watches a debounced "supply is good" comparator. Once the supply is good, it turns on three regulators in a fixed order, one per clock: regulator 3, then regulator 2, then regulator 1.

After the last regulator is on, it builds an active-low reset for the downstream processor. The reset is held low for a long interval, then released high for a short interval. After that it tracks a debounced external reset input. During startup, that external input is masked until a set number of cycles has passed since power-on.

While tracking, a debounced "supply is low" comparator can shut all three regulators off and pull the reset low. The reference keep-alive flag stays up through this shutdown. The machine then goes back to watching for a good supply and starts the sequence again. Every interval is a parameter counted in clock cycles.

Top module: `supply_seq`

## Requirements
- R1: While `por_n` is low, the three regulator enables, `proc_rst_n` and `ref_keep` are all 0, whatever the other inputs do.
- R2: After `por_n` rises, the block idles for `T_INIT` clock edges. `ref_keep` rises on edge `T_INIT` and no regulator turns on before edge `T_INIT+1`, even if the supply-good input is already high.
- R3: Regulators turn on only after the debounced supply-good signal is 1. `reg3_en`, `reg2_en` and `reg1_en` then rise on three consecutive edges, in that order. The state machine reacts one edge after the debounced value changes.
- R4: `proc_rst_n` stays 0 until `T_LOW` edges after `reg1_en` rises. It is then 1 for exactly `T_HIGH` edges before it starts tracking the external reset.
- R5: In the tracking phase, `proc_rst_n` equals the debounced `ext_rst_n`. The output follows a held input change on the 4th edge after the change.
- R6: Until `T_MASK` edges have passed since `por_n` rose, the external reset is treated as released (1). A low input first shows at `proc_rst_n` on edge `T_MASK+1`.
- R7: Each of `good_raw`, `low_raw` and `ext_rst_n` is debounced in both directions. A level that is sampled on only one edge is dropped. A level held for two sampling edges is accepted on the edge after that.
- R8: In the tracking phase, a debounced supply-low (`low_raw` = 1) clears all three enables and drives `proc_rst_n` to 0 on the 4th edge after the input rises. `ref_keep` stays 1.
- R9: `low_raw` has no effect outside the tracking phase. The enables stay on, and the timing of the low and high reset intervals does not change.
- R10: After a supply-low shutdown, the block waits for supply-good again and then repeats the enable order of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, about 10 kHz |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| good_raw | input | 1 | Raw comparator: supply above the rising threshold |
| low_raw | input | 1 | Raw comparator: supply below the falling threshold |
| ext_rst_n | input | 1 | Raw external reset request, active low |
| reg1_en | output | 1 | Enable for regulator 1 |
| reg2_en | output | 1 | Enable for regulator 2 |
| reg3_en | output | 1 | Enable for regulator 3 |
| proc_rst_n | output | 1 | Active-low reset to the downstream processor |
| ref_keep | output | 1 | Keeps the supply reference powered |

## Verification
The bench builds the block with `T_INIT`=3, `T_LOW`=20, `T_HIGH`=5 and `T_MASK`=60. These short values keep both reset intervals and the external-reset mask within a few dozen cycles. With them, the bench can count every boundary edge exactly. It can also see the mask expire while the block is already tracking, and it can run a full shutdown and restart with a supply-low pulse placed inside the low interval.

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int T_INIT = 3,
  parameter int T_LOW  = 2200,
  parameter int T_HIGH = 10,
  parameter int T_MASK = 5000
) (
  input  logic clk,
  input  logic por_n,
  input  logic good_raw,
  input  logic low_raw,
  input  logic ext_rst_n,
  output logic reg1_en,
  output logic reg2_en,
  output logic reg3_en,
  output logic proc_rst_n,
  output logic ref_keep
);
  localparam int TMAX = (T_LOW > T_HIGH) ? ((T_LOW > T_INIT) ? T_LOW : T_INIT)
                                         : ((T_HIGH > T_INIT) ? T_HIGH : T_INIT);
  localparam int CW = $clog2(TMAX + 1);
  localparam int MW = $clog2(T_MASK + 1);

  typedef enum logic [2:0] {
    S_WAIT, S_SAMPLE, S_EN3, S_EN2, S_RLOW, S_RHIGH, S_FOLLOW
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [MW-1:0] mcnt;
  logic [2:0]    s0, s1, deb;
  logic          good_d, low_d, ext_d, mask_done, ext_eff;

  // bit 0: good, bit 1: low, bit 2: external reset
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      s0  <= 3'b100;
      s1  <= 3'b100;
      deb <= 3'b100;
    end else begin
      s0  <= {ext_rst_n, low_raw, good_raw};
      s1  <= s0;
      deb <= (s0 & s1) | (deb & (s0 | s1));
    end

  assign good_d    = deb[0];
  assign low_d     = deb[1];
  assign ext_d     = deb[2];
  assign mask_done = (mcnt == MW'(T_MASK));
  assign ext_eff   = ext_d | ~mask_done;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) mcnt <= '0;
    else if (!mask_done) mcnt <= mcnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      state      <= S_WAIT;
      cnt        <= '0;
      reg1_en    <= 1'b0;
      reg2_en    <= 1'b0;
      reg3_en    <= 1'b0;
      proc_rst_n <= 1'b0;
      ref_keep   <= 1'b0;
    end else begin
      case (state)
        S_WAIT:
          if (cnt == CW'(T_INIT - 1)) begin
            state    <= S_SAMPLE;
            cnt      <= '0;
            ref_keep <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_SAMPLE:
          if (good_d) begin
            state   <= S_EN3;
            reg3_en <= 1'b1;
          end
        S_EN3: begin
          state   <= S_EN2;
          reg2_en <= 1'b1;
        end
        S_EN2: begin
          state   <= S_RLOW;
          reg1_en <= 1'b1;
          cnt     <= '0;
        end
        S_RLOW:
          if (cnt == CW'(T_LOW - 1)) begin
            state      <= S_RHIGH;
            proc_rst_n <= 1'b1;
            cnt        <= '0;
          end else cnt <= cnt + 1'b1;
        S_RHIGH:
          if (cnt == CW'(T_HIGH - 1)) begin
            state      <= S_FOLLOW;
            proc_rst_n <= ext_eff;
            cnt        <= '0;
          end else cnt <= cnt + 1'b1;
        S_FOLLOW:
          if (low_d) begin
            state      <= S_SAMPLE;
            reg1_en    <= 1'b0;
            reg2_en    <= 1'b0;
            reg3_en    <= 1'b0;
            proc_rst_n <= 1'b0;
          end else proc_rst_n <= ext_eff;
        default: state <= S_WAIT;
      endcase
    end

  p_order_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg2_en) |-> reg3_en && $past(reg3_en));
  p_last_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg1_en) |-> reg2_en && $past(reg2_en));
  p_rst_needs_regs_r4: assert property (@(posedge clk) disable iff (!por_n)
    proc_rst_n |-> reg1_en && reg2_en && reg3_en);
  p_follow_r5: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_FOLLOW && !low_d) |=> proc_rst_n == $past(ext_eff));
  p_deb_r7: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(deb) |-> $past(s0) == $past(s1));
  p_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
    ref_keep |=> ref_keep);
  p_shut_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_FOLLOW && low_d) |=> !reg1_en && !reg2_en && !reg3_en && !proc_rst_n);
  p_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_RLOW) |=> reg1_en && reg2_en && reg3_en);
endmodule

// File: tb/supply_seq_tb.sv
module supply_seq_tb;
  localparam int CLK_P  = 10;
  localparam int T_INIT = 3;
  localparam int T_LOW  = 20;
  localparam int T_HIGH = 5;
  localparam int T_MASK = 60;

  logic clk = 1'b0, por_n = 1'b0;
  logic good_raw = 1'b0, low_raw = 1'b0, ext_rst_n = 1'b1;
  logic reg1_en, reg2_en, reg3_en, proc_rst_n, ref_keep;
  int total = 0, bad = 0, ecount = 0;

  supply_seq #(.T_INIT(T_INIT), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_MASK(T_MASK)) u_dut (
    .clk(clk), .por_n(por_n), .good_raw(good_raw), .low_raw(low_raw),
    .ext_rst_n(ext_rst_n), .reg1_en(reg1_en), .reg2_en(reg2_en), .reg3_en(reg3_en),
    .proc_rst_n(proc_rst_n), .ref_keep(ref_keep));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (por_n) ecount <= ecount + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int outs();
    return {reg3_en, reg2_en, reg1_en, proc_rst_n, ref_keep};
  endfunction

  task automatic t_reset_r1;
    por_n = 1'b0; good_raw = 1'b1; low_raw = 1'b1; ext_rst_n = 1'b0;
    step(4);
    chk("R1 outputs in reset", outs(), 0);
    good_raw = 1'b0; low_raw = 1'b0; ext_rst_n = 1'b1;
    step(1);
    por_n = 1'b1;
  endtask

  task automatic t_startup_r2_r3_r7;
    step(T_INIT - 1);
    chk("R2 ref_keep before settle", ref_keep, 0);
    step(1);
    chk("R2 ref_keep after settle", ref_keep, 1);
    good_raw = 1'b1; step(1); good_raw = 1'b0;
    step(6);
    chk("R7 one-edge good pulse dropped", reg3_en, 0);
    good_raw = 1'b1;
    step(3);
    chk("R3 no enable before debounce", reg3_en, 0);
    step(1);
    chk("R3 reg3 first", {reg3_en, reg2_en, reg1_en}, 3'b100);
    step(1);
    chk("R3 reg2 second", {reg3_en, reg2_en, reg1_en}, 3'b110);
    step(1);
    chk("R3 reg1 third", {reg3_en, reg2_en, reg1_en}, 3'b111);
  endtask

  task automatic t_reset_shape_r4_r6;
    ext_rst_n = 1'b0;
    step(T_LOW - 1);
    chk("R4 reset still low", proc_rst_n, 0);
    step(1);
    chk("R4 reset released", proc_rst_n, 1);
    step(T_HIGH + 3);
    chk("R6 external low masked", proc_rst_n, 1);
    while (ecount < T_MASK) step(1);
    chk("R6 masked at edge T_MASK", proc_rst_n, 1);
    step(1);
    chk("R6 mask expired", proc_rst_n, 0);
  endtask

  task automatic t_follow_r5_r7;
    ext_rst_n = 1'b1;
    step(3);
    chk("R5 follow latency", proc_rst_n, 0);
    step(1);
    chk("R5 follows release", proc_rst_n, 1);
    ext_rst_n = 1'b0; step(1); ext_rst_n = 1'b1;
    step(6);
    chk("R7 one-edge ext pulse dropped", proc_rst_n, 1);
    ext_rst_n = 1'b0; step(2); ext_rst_n = 1'b1;
    step(2);
    chk("R7 two-edge ext pulse accepted", proc_rst_n, 0);
    step(4);
    chk("R5 follows back high", proc_rst_n, 1);
  endtask

  task automatic t_shutdown_r8;
    good_raw = 1'b0;
    step(5);
    low_raw = 1'b1;
    step(3);
    chk("R8 enables before shutdown", {reg3_en, reg2_en, reg1_en}, 3'b111);
    step(1);
    chk("R8 shutdown outputs", outs(), 1);
    low_raw = 1'b0;
    step(10);
    chk("R10 idle without good", outs(), 1);
  endtask

  task automatic t_restart_r9_r10;
    good_raw = 1'b1;
    step(4);
    chk("R10 reg3 restart", {reg3_en, reg2_en, reg1_en}, 3'b100);
    step(1);
    chk("R10 reg2 restart", {reg3_en, reg2_en, reg1_en}, 3'b110);
    step(1);
    chk("R10 reg1 restart", {reg3_en, reg2_en, reg1_en}, 3'b111);
    ext_rst_n = 1'b0;
    low_raw = 1'b1;
    step(8);
    low_raw = 1'b0;
    chk("R9 low ignored in low interval", {reg3_en, reg2_en, reg1_en, proc_rst_n}, 4'b1110);
    step(T_LOW - 9);
    chk("R9 reset still low at T_LOW-1", proc_rst_n, 0);
    step(1);
    chk("R9 reset released on time", {reg3_en, reg2_en, reg1_en, proc_rst_n}, 4'b1111);
    step(T_HIGH - 1);
    chk("R4 high interval end", proc_rst_n, 1);
    step(1);
    chk("R4 high interval exact", proc_rst_n, 0);
    ext_rst_n = 1'b1;
    step(4);
    chk("R5 release after restart", proc_rst_n, 1);
  endtask

  task automatic t_async_r1;
    #2 por_n = 1'b0;
    #1;
    chk("R1 async reset clears", outs(), 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_r1;
    t_startup_r2_r3_r7;
    t_reset_shape_r4_r6;
    t_follow_r5_r7;
    t_shutdown_r8;
    t_restart_r9_r10;
    t_async_r1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule